// File: doc/BRIEF.md
# Register-Port Serial Slave with Address Pointer

This block is a two-wire serial bus slave that lets a host read and write a small bank of byte-wide control registers. SCL and SDA are sampled on a fast system clock through a two-flop synchroniser and a glitch filter. The filtered lines drive edge detection for START, repeated START and STOP conditions. The block decodes a 7-bit device address whose lowest bit comes from a strap input, and it pulls SDA low only through an open-drain output enable.

A write transfer loads an internal register pointer from its first data byte. Each later byte goes into the register the pointer selects, and the pointer then advances. A read transfer returns register contents starting at the pointer left by the last write, with the pointer advancing after every byte. The master ends a read by answering a byte with NACK. The slave's acknowledge is driven after a delay counted in system clocks. That delay shrinks with a speed-mode setting, so it stays within a fixed number of sample-rate-derived timebase ticks.

Top module: `i2c_regport`

## Requirements
- R1: After reset is released, sda_oe_o is low and every register reads zero. A START issued 40 system clocks (320 ns) after reset release is recognised and its matching address is acknowledged.
- R2: The device address is the 7-bit value 0b001100s, where s is the level of addr_strap_i. It is sent MSB first and followed by the R/W bit (0 = write, 1 = read). On a match, the slave pulls SDA low (sda_oe_o high) during the ninth clock.
- R3: On a non-matching address, the slave does not acknowledge. It then drives nothing and writes no register until the next START or STOP.
- R4: In a write transfer, the first byte after the address loads the pointer. Each following byte is written to register[pointer], and the pointer increments after each such byte. Every byte is acknowledged.
- R5: In a read transfer, the slave sends register[pointer] MSB first and then increments the pointer. A master ACK (SDA low in the ninth clock) continues with the next register. A master NACK ends the read, and the slave drives nothing until the next START or STOP.
- R6: Registers are indexed 0 to 7. A write while the pointer is 8 or more changes no register, and a read from such a pointer returns 0x00.
- R7: After the falling SCL edge that ends a byte, sda_oe_o rises after a timer delay plus a fixed front-end latency. The timer delay is ACK_DLY_CLKS system clocks for speed_mode_i = 0, half that for 1, and a quarter for 2 or 3. The measured latency lies between the timer delay and the timer delay plus 12 clocks.
- R8: sda_oe_o is high only during an acknowledge bit the slave sends or a zero read-data bit. It is low after every STOP.
- R9: A pulse shorter than FILT_LEN system clocks on SCL or SDA has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| addr_strap_i | input | 1 | Device address bit 0 |
| speed_mode_i | input | 2 | Acknowledge timebase select: 0 single, 1 double, 2/3 quad |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA |
| regs_o | output | NUM_REGS*8 | Register bank contents, register i at bits [8i+7:8i] |

## Verification
The assertions check on every cycle that the SDA enable appears only in an acknowledge or transmit state and drops after STOP. They also check that a START always returns the slave to address reception, that an ignored transfer never writes the bank, that a write to an out-of-range pointer leaves the bank unchanged, and that the slave never waits longer than the acknowledge timer allows. Only the bench scenarios can show the byte-level effects: pointer loading and auto-increment across writes and repeated-START reads, the strap-selected address, master NACK ending a read, the ordering of latencies across speed modes, and rejection of line glitches.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_IGNORE
  } state_e;

  localparam logic [5:0] DEV_ADDR_HI = 6'b001100;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } spd_e;
endpackage

// File: rtl/i2c_regport_filt.sv
module i2c_regport_filt #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  // output follows only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != out_q) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          out_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/i2c_regport_ack_tmr.sv
module i2c_regport_ack_tmr
  import i2c_regport_pkg::*;
#(
  parameter int unsigned DLY_CLKS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] spd_i,
  input  logic       start_i,
  input  logic       clr_i,
  output logic       fire_o
);
  localparam int unsigned CW = $clog2(DLY_CLKS + 1);

  logic [CW-1:0] dly;
  logic [CW-1:0] cnt_q;
  logic          arm_q;

  always_comb begin
    unique case (spd_e'(spd_i))
      SPD_SINGLE: dly = CW'(DLY_CLKS);
      SPD_DOUBLE: dly = CW'(DLY_CLKS / 2);
      default:    dly = CW'(DLY_CLKS / 4);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      arm_q <= 1'b0;
    end else if (start_i) begin
      arm_q <= 1'b1;
      cnt_q <= dly;
    end else if (arm_q) begin
      if (cnt_q == '0) arm_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fire_o = arm_q && (cnt_q == '0);
endmodule

// File: rtl/i2c_regport_bank.sv
module i2c_regport_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [AW-1:0]          raddr_i,
  output logic [DW-1:0]          rdata_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  logic [DW-1:0] mem_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    // out-of-range addresses match no register
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem_q[i] <= '0;
      else if (we_i && waddr_i == AW'(i))    mem_q[i] <= wdata_i;
    end
    assign regs_o[i*DW +: DW] = mem_q[i];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (raddr_i == AW'(i)) rdata_o = mem_q[i];
    end
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int unsigned NUM_REGS     = 8,
  parameter int unsigned FILT_LEN     = 3,
  parameter int unsigned ACK_DLY_CLKS = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic                       addr_strap_i,
  input  logic [1:0]                 speed_mode_i,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  localparam int unsigned PTR_W = 8;
  localparam int unsigned BIT_W = 4;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W);

  // front end
  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_regport_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_evt, stop_evt;
  assign scl_rise  = scl_f && !scl_q;
  assign scl_fall  = !scl_f && scl_q;
  assign start_evt = scl_f && scl_q && sda_q && !sda_f;
  assign stop_evt  = scl_f && scl_q && !sda_q && sda_f;

  // protocol state
  state_e             state_q;
  logic [BIT_W-1:0]   bit_cnt_q;
  logic [BYTE_W-1:0]  rx_q, tx_q;
  logic [PTR_W-1:0]   ptr_q;
  logic               ptr_loaded_q, rw_q, nack_q, oe_q;

  logic               addr_done, addr_match, rx_done;
  logic               tmr_start, tmr_clr, tmr_fire;
  logic               bank_we;
  logic [BYTE_W-1:0]  bank_rdata;

  assign addr_done  = (state_q == ST_ADDR) && scl_fall && (bit_cnt_q == LAST_BIT);
  assign addr_match = (rx_q[7:1] == {DEV_ADDR_HI, addr_strap_i});
  assign rx_done    = (state_q == ST_RX) && scl_fall && (bit_cnt_q == LAST_BIT);
  assign tmr_start  = (addr_done && addr_match) || rx_done;
  assign tmr_clr    = start_evt || stop_evt;
  assign bank_we    = rx_done && ptr_loaded_q;

  i2c_regport_ack_tmr #(.DLY_CLKS(ACK_DLY_CLKS)) u_ack_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .spd_i  (speed_mode_i),
    .start_i(tmr_start),
    .clr_i  (tmr_clr),
    .fire_o (tmr_fire)
  );

  i2c_regport_bank #(.NUM_REGS(NUM_REGS), .DW(BYTE_W), .AW(PTR_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bank_we),
    .waddr_i(ptr_q),
    .wdata_i(rx_q),
    .raddr_i(ptr_q),
    .rdata_o(bank_rdata),
    .regs_o (regs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      bit_cnt_q    <= '0;
      rx_q         <= '0;
      tx_q         <= '0;
      ptr_q        <= '0;
      ptr_loaded_q <= 1'b0;
      rw_q         <= 1'b0;
      nack_q       <= 1'b0;
      oe_q         <= 1'b0;
    end else if (start_evt) begin
      state_q      <= ST_ADDR;
      bit_cnt_q    <= '0;
      ptr_loaded_q <= 1'b0;
      oe_q         <= 1'b0;
    end else if (stop_evt) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_q      <= {rx_q[6:0], sda_f};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (addr_done) begin
            if (addr_match) begin
              state_q <= ST_ADDR_ACK;
              rw_q    <= rx_q[0];
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (tmr_fire) oe_q <= 1'b1;
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              state_q <= ST_TX;
              tx_q    <= bank_rdata;
              oe_q    <= !bank_rdata[7];
            end else begin
              state_q <= ST_RX;
              oe_q    <= 1'b0;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            rx_q      <= {rx_q[6:0], sda_f};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (rx_done) begin
            state_q <= ST_RX_ACK;
            if (!ptr_loaded_q) begin
              ptr_q        <= rx_q;
              ptr_loaded_q <= 1'b1;
            end else begin
              ptr_q <= ptr_q + 1'b1;
            end
          end
        end
        ST_RX_ACK: begin
          if (tmr_fire) oe_q <= 1'b1;
          if (scl_fall) begin
            oe_q      <= 1'b0;
            state_q   <= ST_RX;
            bit_cnt_q <= '0;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt_q == LAST_BIT) begin
              oe_q    <= 1'b0;
              state_q <= ST_TX_ACK;
              ptr_q   <= ptr_q + 1'b1;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= !tx_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            nack_q <= sda_f;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_q <= ST_IGNORE;
            end else begin
              state_q   <= ST_TX;
              bit_cnt_q <= '0;
              tx_q      <= bank_rdata;
              oe_q      <= !bank_rdata[7];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk
  import i2c_regport_pkg::*;
#(
  parameter int unsigned NUM_REGS     = 8,
  parameter int unsigned ACK_DLY_CLKS = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       sda_oe_o,
  input state_e                     state_q,
  input logic                       start_evt,
  input logic                       stop_evt,
  input logic                       bank_we,
  input logic [7:0]                 ptr_q,
  input logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic [15:0] wait_cnt_q;
  logic        in_ack;
  assign in_ack = (state_q == ST_ADDR_ACK) || (state_q == ST_RX_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wait_cnt_q <= '0;
    else if (in_ack && !sda_oe_o) wait_cnt_q <= wait_cnt_q + 1'b1;
    else                        wait_cnt_q <= '0;
  end

  p_oe_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (state_q == ST_ADDR_ACK || state_q == ST_RX_ACK || state_q == ST_TX));

  p_stop_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> (state_q == ST_IDLE && !sda_oe_o));

  p_start_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> (state_q == ST_ADDR));

  p_ignore_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !bank_we);

  p_oob_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we && ptr_q >= 8'(NUM_REGS)) |=> $stable(regs_o));

  p_ack_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_cnt_q <= 16'(ACK_DLY_CLKS + 2));
endmodule

bind i2c_regport i2c_regport_chk #(
  .NUM_REGS    (NUM_REGS),
  .ACK_DLY_CLKS(ACK_DLY_CLKS)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sda_oe_o (sda_oe_o),
  .state_q  (state_q),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .bank_we  (bank_we),
  .ptr_q    (ptr_q),
  .regs_o   (regs_o)
);

// File: tb/i2c_regport_tb_top.sv
`timescale 1ns/1ps
module i2c_regport_tb_top;
  localparam int NREG = 8;
  localparam int DLY  = 16;
  localparam int HALF = 48;
  localparam int Q    = HALF / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic [1:0] spd = 2'd0;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  wire  sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_regport #(.NUM_REGS(NREG), .FILT_LEN(3), .ACK_DLY_CLKS(DLY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_strap_i(strap), .speed_mode_i(spd), .sda_oe_o(sda_oe), .regs_o(regs)
  );

  int n_chk = 0, n_fail = 0, oe_hits = 0;
  logic [NREG*8-1:0] exp_regs = '0;

  task automatic check(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      if (sda_oe) oe_hits++;
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl = 1'b0;
  endtask

  task automatic bus_restart();
    tick(Q); sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gl, output bit ack, output int lat);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = b[i]; tick(Q);
      scl = 1'b1;
      if (gl && i == 6) begin
        tick(Q); sda_m = 1'b0; tick(2); sda_m = b[i]; tick(Q - 2);
      end else if (gl && i == 4) begin
        tick(Q); scl = 1'b0; tick(1); scl = 1'b1; tick(Q - 1);
      end else begin
        tick(HALF);
      end
      scl = 1'b0;
    end
    lat = -1;
    for (int i = 0; i < HALF; i++) begin
      if (i == Q) sda_m = 1'b1;
      @(negedge clk);
      if (sda_oe && lat < 0) lat = i + 1;
    end
    scl = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q); scl = 1'b0;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q); sda_m = 1'b1; tick(Q);
      scl = 1'b1; tick(Q);
      d = {d[6:0], sda_line};
      tick(Q); scl = 1'b0;
    end
    tick(Q); sda_m = !mack; tick(Q);
    scl = 1'b1; tick(HALF); scl = 1'b0;
  endtask

  task automatic wr_seq(input logic [7:0] dev, input logic [7:0] ptr, input logic [7:0] d0,
                        input logic [7:0] d1, input int nd, input string tag);
    bit a; int l;
    bus_start();
    send_byte({dev[6:0], 1'b0}, 1'b0, a, l);
    send_byte(ptr, 1'b0, a, l);
    check({tag, " ptr ack"}, a, a, 1);
    if (nd > 0) begin send_byte(d0, 1'b0, a, l); check({tag, " d0 ack"}, a, a, 1); end
    if (nd > 1) begin send_byte(d1, 1'b0, a, l); check({tag, " d1 ack"}, a, a, 1); end
    bus_stop();
  endtask

  task automatic t_reset();
    bit a; int l;
    check("R1 oe at reset", sda_oe == 1'b0, sda_oe, 0);
    check("R1 regs at reset", regs == '0, regs, 0);
    tick(40);
    bus_start();
    send_byte(8'h30, 1'b0, a, l);
    check("R1 early start acked", a, a, 1);
    bus_stop();
  endtask

  task automatic t_write();
    wr_seq(8'h18, 8'h02, 8'hA5, 8'h3C, 2, "R4");
    exp_regs[2*8 +: 8] = 8'hA5;
    exp_regs[3*8 +: 8] = 8'h3C;
    check("R4 regs after write with autoinc", regs == exp_regs, regs, exp_regs);
    check("R8 oe released after stop", sda_oe == 1'b0, sda_oe, 0);
  endtask

  task automatic t_read();
    bit a; int l; logic [7:0] d;
    bus_start();
    send_byte(8'h30, 1'b0, a, l);
    send_byte(8'h02, 1'b0, a, l);
    bus_restart();
    send_byte(8'h31, 1'b0, a, l);
    check("R2 read addr ack", a, a, 1);
    read_byte(1'b1, d);
    check("R5 read byte0", d == 8'hA5, d, 8'hA5);
    read_byte(1'b0, d);
    check("R5 read byte1 autoinc", d == 8'h3C, d, 8'h3C);
    oe_hits = 0;
    read_byte(1'b0, d);
    check("R5 no drive after master NACK", oe_hits == 0, oe_hits, 0);
    check("R5 line idle after NACK", d == 8'hFF, d, 8'hFF);
    bus_stop();
    check("R5 read leaves regs", regs == exp_regs, regs, exp_regs);
  endtask

  task automatic t_badaddr();
    bit a; int l;
    strap = 1'b0;
    bus_start();
    oe_hits = 0;
    send_byte(8'h32, 1'b0, a, l);
    check("R3 wrong addr nack", !a, a, 0);
    send_byte(8'h00, 1'b0, a, l);
    send_byte(8'hFF, 1'b0, a, l);
    check("R3 no drive while ignoring", oe_hits == 0, oe_hits, 0);
    bus_stop();
    check("R3 regs untouched", regs == exp_regs, regs, exp_regs);
  endtask

  task automatic t_strap();
    bit a; int l;
    strap = 1'b1;
    tick(4);
    wr_seq(8'h19, 8'h00, 8'h5A, 8'h00, 1, "R2 strap");
    exp_regs[7:0] = 8'h5A;
    check("R2 strap=1 write lands", regs == exp_regs, regs, exp_regs);
    bus_start();
    send_byte(8'h30, 1'b0, a, l);
    check("R3 strap=1 rejects 0x18", !a, a, 0);
    bus_stop();
    strap = 1'b0;
    tick(4);
  endtask

  task automatic t_oob();
    bit a; int l; logic [7:0] d;
    wr_seq(8'h18, 8'h07, 8'h11, 8'h22, 2, "R6");
    exp_regs[7*8 +: 8] = 8'h11;
    check("R6 write past end ignored", regs == exp_regs, regs, exp_regs);
    wr_seq(8'h18, 8'h09, 8'h77, 8'h00, 1, "R6 far");
    check("R6 far pointer write ignored", regs == exp_regs, regs, exp_regs);
    wr_seq(8'h18, 8'h07, 8'h00, 8'h00, 0, "R6 ptr");
    bus_start();
    send_byte(8'h31, 1'b0, a, l);
    read_byte(1'b1, d);
    check("R6 read reg7", d == 8'h11, d, 8'h11);
    read_byte(1'b0, d);
    check("R6 read past end is zero", d == 8'h00, d, 8'h00);
    bus_stop();
  endtask

  task automatic t_speed();
    bit a; int l; int lats[3];
    for (int m = 0; m < 3; m++) begin
      spd = 2'(m);
      tick(4);
      bus_start();
      send_byte(8'h30, 1'b0, a, l);
      lats[m] = l;
      check($sformatf("R7 ack mode %0d", m), a, a, 1);
      check($sformatf("R7 latency mode %0d in range", m),
            l >= (DLY >> (2 * m > 2 ? 2 : m)) && l <= (DLY >> m) + 12, l, DLY >> m);
      bus_stop();
    end
    check("R7 latency shrinks double vs single", lats[1] < lats[0], lats[1], lats[0]);
    check("R7 latency shrinks quad vs double", lats[2] < lats[1], lats[2], lats[1]);
    spd = 2'd0;
  endtask

  task automatic t_glitch();
    bit a; int l;
    bus_start();
    send_byte(8'h30, 1'b0, a, l);
    send_byte(8'h04, 1'b0, a, l);
    send_byte(8'hF0, 1'b1, a, l);
    check("R9 glitched byte acked", a, a, 1);
    bus_stop();
    exp_regs[4*8 +: 8] = 8'hF0;
    check("R9 glitched byte written intact", regs == exp_regs, regs, exp_regs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_read();
    t_badaddr();
    t_strap();
    t_oob();
    t_speed();
    t_glitch();
    tick(10);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule